// File: doc/BRIEF.md
# Banked Address Decoder with Access Timing

This block sits between a CPU core with a 24-bit address (an 8-bit bank byte above a 16-bit offset) and the memories and register files behind it. When an access is started, it classifies the address into one of seven target regions, translates it into a cartridge ROM address for either of two cartridge wiring schemes, and times the access. It then raises a one-cycle completion pulse after the number of master clocks that region needs.

Region selection depends on bit 15, bit 22 and the bank byte. If either bit is set, the address falls in the large upper space. That space holds work RAM in the top two RAM banks and cartridge space everywhere else. Cartridge accesses in banks with bit 23 set can be sped up by a fast-ROM enable input. If both bits are clear, the offset alone selects one of several low windows: a work-RAM mirror, two register files, a slow controller port and an expansion window. Offsets in the gaps between these windows decode as unmapped. An unmapped access completes with an open-bus flag instead of data. The decoded region and ROM address are held on the outputs from the start of an access until the next accepted start.

Top module: `bank_decoder`

## Requirements
- R1: When address bit 15 or bit 22 is 1 and the bank byte is 0x7E or 0x7F, the region is work RAM (code 0) and the access lasts 8 clocks.
- R2: When bit 15 or bit 22 is 1 and the bank is neither 0x7E nor 0x7F, the region is cartridge (code 1). It lasts 6 clocks when bit 23 and `fastRomEn` are both 1, and 8 clocks otherwise.
- R3: When bits 15 and 22 are both 0, offsets 0x0000–0x1FFF give work RAM (code 0) with 8 clocks.
- R4: When bits 15 and 22 are both 0, offsets 0x2100–0x21FF give the peripheral register bus (code 2, 6 clocks), and offsets 0x4000–0x41FF give the controller port (code 3, 12 clocks).
- R5: When bits 15 and 22 are both 0, offsets 0x4200–0x43FF give system registers (code 4, 6 clocks), and offsets 0x6000–0x7FFF give expansion (code 5, 8 clocks).
- R6: When bits 15 and 22 are both 0, offsets 0x2000–0x20FF, 0x2200–0x3FFF and 0x4400–0x5FFF give unmapped (code 6). The access lasts 8 clocks, and `openBus` is 1 together with `done` for exactly that access.
- R7: `romAddr` is `{addr[22:16], addr[14:0]}` when `hiRomMode` is 0, and `addr[21:0]` when it is 1, whatever the region.
- R8: When `start` is accepted at a rising edge, `done` is 1 for exactly one cycle, beginning N rising edges later, where N is the region's clock count.
- R9: A `start` raised while an access is in progress is ignored. The running access keeps its timing and its outputs, and no extra `done` follows. A `start` is accepted again at the first edge after the `done` cycle begins.
- R10: After reset, `done` and `openBus` are 0, `region` is 6 and `romAddr` is 0. `region` and `romAddr` change only when a `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an access when idle |
| cpuAddr | input | 24 | Bank byte [23:16] and offset [15:0] |
| fastRomEn | input | 1 | Enables short cartridge timing for banks with bit 23 set |
| hiRomMode | input | 1 | 0: ROM address drops bit 15; 1: ROM address is bits 21:0 |
| region | output | 3 | Region code of the accepted access |
| romAddr | output | 22 | Translated cartridge ROM address |
| done | output | 1 | One-cycle completion pulse |
| openBus | output | 1 | Marks completion of an unmapped access |

## Verification
Every one of the 256 bank bytes is combined with offsets on both sides of each low-window edge, and with offsets in the upper half. This separates the bit-15 path from the bit-22 path and the low windows from each other. The fast-ROM and mapping-mode inputs toggle with the bank parity, so fast and slow cartridge timing are both seen in banks above and below 0x80, and both ROM translations are seen on each class of address. A separate case raises a second start in the middle of a 12-clock controller access to show that it neither retimes nor relabels the running access.

// File: rtl/bank_decoder_pkg.sv
package bank_decoder_pkg;

  typedef enum logic [2:0] {
    RG_WRAM  = 3'd0,
    RG_CART  = 3'd1,
    RG_PERIF = 3'd2,
    RG_PADIO = 3'd3,
    RG_SYSIO = 3'd4,
    RG_EXPAN = 3'd5,
    RG_OPEN  = 3'd6
  } region_e;

  typedef struct packed {
    logic capture;
    logic finish;
  } ctrl_strobe_t;

endpackage

// File: rtl/bank_decoder_path.sv
module bank_decoder_path
  import bank_decoder_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ROM_W    = 22,
  parameter int FAST_CLK = 6,
  parameter int MID_CLK  = 8,
  parameter int SLOW_CLK = 12,
  parameter int CNT_W    = $clog2(SLOW_CLK + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                fastRomEn,
  input  logic                hiRomMode,
  output logic [CNT_W-1:0]    accessLen,
  output region_e             regionQ,
  output logic [ROM_W-1:0]    romAddrQ,
  output logic                openBusQ
);

  localparam int OFF_W = 16;

  logic [7:0]       bankByte;
  logic [OFF_W-1:0] offset;
  logic             upperSpace;
  logic             fastCart;
  region_e          regionD;
  logic [ROM_W-1:0] romLo;
  logic [ROM_W-1:0] romHi;

  assign bankByte   = cpuAddr[23:16];
  assign offset     = cpuAddr[15:0];
  assign upperSpace = cpuAddr[15] | cpuAddr[22];
  assign fastCart   = cpuAddr[23] & fastRomEn;

  always_comb begin
    regionD   = RG_OPEN;
    accessLen = CNT_W'(MID_CLK);
    if (upperSpace) begin
      if (bankByte[7:1] == 7'h3F) begin
        regionD = RG_WRAM;
      end else begin
        regionD = RG_CART;
        if (fastCart) accessLen = CNT_W'(FAST_CLK);
      end
    end else if (offset < 16'h2000) begin
      regionD = RG_WRAM;
    end else if (offset[15:8] == 8'h21) begin
      regionD   = RG_PERIF;
      accessLen = CNT_W'(FAST_CLK);
    end else if (offset[15:9] == 7'h20) begin
      regionD   = RG_PADIO;
      accessLen = CNT_W'(SLOW_CLK);
    end else if (offset[15:9] == 7'h21) begin
      regionD   = RG_SYSIO;
      accessLen = CNT_W'(FAST_CLK);
    end else if (offset[15:13] == 3'b011) begin
      regionD = RG_EXPAN;
    end
  end

  assign romLo = {cpuAddr[22:16], cpuAddr[14:0]};
  assign romHi = cpuAddr[ROM_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionQ  <= RG_OPEN;
      romAddrQ <= '0;
      openBusQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        regionQ  <= regionD;
        romAddrQ <= hiRomMode ? romHi : romLo;
      end
      openBusQ <= strobe.finish && (regionQ == RG_OPEN);
    end
  end

  // R7: a captured ROM address follows the selected translation
  a_r7_rom_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> romAddrQ == ($past(hiRomMode) ? $past(cpuAddr[ROM_W-1:0])
                                    : {$past(cpuAddr[22:16]), $past(cpuAddr[14:0])}));

  // R10: decoded outputs move only on capture
  a_r10_region_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(regionQ) && $stable(romAddrQ));

endmodule

// File: rtl/bank_decoder_ctrl.sv
module bank_decoder_ctrl
  import bank_decoder_pkg::*;
#(
  parameter int SLOW_CLK = 12,
  parameter int CNT_W    = $clog2(SLOW_CLK + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] accessLen,
  output ctrl_strobe_t     strobe,
  output logic             busy,
  output logic             doneQ
);

  logic [CNT_W-1:0] remain;

  always_comb begin
    strobe.capture = start && !busy;
    strobe.finish  = busy && (remain == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.finish;
      if (strobe.capture) begin
        busy   <= 1'b1;
        remain <= accessLen;
      end else if (busy) begin
        remain <= remain - CNT_W'(1);
        if (strobe.finish) busy <= 1'b0;
      end
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R8: completion only ends a running access
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(busy) && !busy);

  // R9: a running access counts down without being restarted
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (busy && remain > CNT_W'(1)) |=> busy && (remain == $past(remain) - CNT_W'(1)));

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_decoder_pkg::*;
#(
  parameter int FAST_CLK = 6,
  parameter int MID_CLK  = 8,
  parameter int SLOW_CLK = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [23:0] cpuAddr,
  input  logic        fastRomEn,
  input  logic        hiRomMode,
  output logic [2:0]  region,
  output logic [21:0] romAddr,
  output logic        done,
  output logic        openBus
);

  localparam int CNT_W = $clog2(SLOW_CLK + 1);

  ctrl_strobe_t     strobe;
  logic [CNT_W-1:0] accessLen;
  logic             busy;
  region_e          regionQ;

  bank_decoder_ctrl #(.SLOW_CLK(SLOW_CLK), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .accessLen(accessLen),
    .strobe(strobe), .busy(busy), .doneQ(done)
  );

  bank_decoder_path #(
    .ADDR_W(24), .ROM_W(22), .FAST_CLK(FAST_CLK), .MID_CLK(MID_CLK),
    .SLOW_CLK(SLOW_CLK), .CNT_W(CNT_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr),
    .fastRomEn(fastRomEn), .hiRomMode(hiRomMode), .accessLen(accessLen),
    .regionQ(regionQ), .romAddrQ(romAddr), .openBusQ(openBus)
  );

  assign region = regionQ;

  // R6: the open-bus flag only accompanies completion
  a_r6_open_with_done: assert property (@(posedge clk) disable iff (!rstN)
    openBus |-> done && region == 3'd6);

  // R9: outputs are frozen for the whole access
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(region) && $stable(romAddr));

endmodule

// File: tb/bank_decoder_tb.sv
module bank_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic        fastRomEn = 1'b0;
  logic        hiRomMode = 1'b0;
  logic [2:0]  region;
  logic [21:0] romAddr;
  logic        done;
  logic        openBus;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bank_decoder u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cpuAddr(cpuAddr),
    .fastRomEn(fastRomEn), .hiRomMode(hiRomMode), .region(region),
    .romAddr(romAddr), .done(done), .openBus(openBus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int modelRegion(input int a);
    int bank = (a >> 16) & 255;
    int ofs  = a & 65535;
    if (((a >> 15) & 1) == 1 || ((a >> 22) & 1) == 1)
      return (bank == 126 || bank == 127) ? 0 : 1;
    if (ofs < 8192) return 0;
    if (ofs >= 8448 && ofs < 8704) return 2;
    if (ofs >= 16384 && ofs < 16896) return 3;
    if (ofs >= 16896 && ofs < 17408) return 4;
    if (ofs >= 24576 && ofs < 32768) return 5;
    return 6;
  endfunction

  function automatic int modelLen(input int a, input int reg_, input int fast);
    case (reg_)
      1: return (((a >> 23) & 1) == 1 && fast == 1) ? 6 : 8;
      2, 4: return 6;
      3: return 12;
      default: return 8;
    endcase
  endfunction

  function automatic int modelRom(input int a, input int hi);
    if (hi == 1) return a % 4194304;
    return ((a >> 16) % 128) * 32768 + (a % 32768);
  endfunction

  function automatic string tagOf(input int reg_, input int a);
    if (reg_ == 1) return "R2";
    if (reg_ == 0) return (((a >> 15) & 1) == 1 || ((a >> 22) & 1) == 1) ? "R1" : "R3";
    if (reg_ == 2 || reg_ == 3) return "R4";
    if (reg_ == 4 || reg_ == 5) return "R5";
    return "R6";
  endfunction

  task automatic runAccess(input int a, input bit fast, input bit hi);
    int expReg = modelRegion(a);
    int expLen = modelLen(a, expReg, int'(fast));
    int expRom = modelRom(a, int'(hi));
    string tg = tagOf(expReg, a);
    int k = 0;
    @(negedge clk);
    start = 1'b1; cpuAddr = a[23:0]; fastRomEn = fast; hiRomMode = hi;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (k < 40) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (done) break;
    end
    check(k == expLen, "R8 duration", k, expLen);
    check(int'(region) == expReg, tg, int'(region), expReg);
    check(int'(romAddr) == expRom, "R7 rom address", int'(romAddr), expRom);
    check(openBus == (expReg == 6), "R6 open bus", int'(openBus), int'(expReg == 6));
    @(posedge clk);
    @(negedge clk);
    check(!done && !openBus, "R8 single pulse", int'(done), 0);
  endtask

  initial begin
    int offs [18] = '{'h0000, 'h1FFF, 'h2000, 'h20FF, 'h2100, 'h21FF, 'h2200, 'h3FFF,
                      'h4000, 'h41FF, 'h4200, 'h43FF, 'h4400, 'h5FFF, 'h6000, 'h7FFF,
                      'h8000, 'hFFFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset values
    check(!done && !openBus, "R10 reset flags", int'(done), 0);
    check(region == 3'd6, "R10 reset region", int'(region), 6);
    check(romAddr == '0, "R10 reset romAddr", int'(romAddr), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int b = 0; b < 256; b++) begin
      for (int i = 0; i < 18; i++) begin
        int a = (b << 16) | (offs[i] ^ ((b * 37) & 16'h00FF));
        if (offs[i] == 'h20FF || offs[i] == 'h21FF || offs[i] == 'h41FF || offs[i] == 'h43FF)
          a = (b << 16) | offs[i];
        if (offs[i] == 'h0000 || offs[i] == 'h2000 || offs[i] == 'h2100 || offs[i] == 'h4000 ||
            offs[i] == 'h4200 || offs[i] == 'h6000)
          a = (b << 16) | offs[i];
        runAccess(a, bit'((b ^ i) & 1), bit'(((b >> 1) ^ i) & 1));
      end
    end

    // R9: second start in the middle of a controller-port access
    begin
      int k = 0;
      int extra = 0;
      @(negedge clk);
      start = 1'b1; cpuAddr = 24'h004000; fastRomEn = 1'b0; hiRomMode = 1'b0;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (3) begin @(posedge clk); k++; @(negedge clk); end
      start = 1'b1; cpuAddr = 24'h7E0000; fastRomEn = 1'b1; hiRomMode = 1'b1;
      @(posedge clk); k++; @(negedge clk);
      start = 1'b0;
      check(region == 3'd3, "R9 region kept", int'(region), 3);
      check(romAddr == 22'h004000, "R9 romAddr kept", int'(romAddr), 'h4000);
      while (k < 40) begin
        @(posedge clk); k++; @(negedge clk);
        if (done) break;
      end
      check(k == 12, "R9 timing kept", k, 12);
      for (int j = 0; j < 16; j++) begin
        @(posedge clk); @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R9 no extra done", extra, 0);
      check(region == 3'd3, "R10 region held when idle", int'(region), 3);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule